// File: doc/BRIEF.md
# Auxiliary-Channel Request Framing Buffer

This block holds one outgoing auxiliary-channel request in a small byte buffer and plays it out as a byte stream. Software fills the buffer through a set of write strobes. A header write packs a 4-bit command and a 20-bit address into the first bytes, adds a length byte when the transfer length is non-zero, and works out how many bytes the request occupies. Payload bytes then go in through an indexed data port whose pointer can advance on its own or stay fixed.

A start delay and, if needed, an explicit byte count are programmed before the launch strobe. After launch the engine idles for the programmed number of cycles. It then presents the buffer bytes in order on a valid/ready stream and raises a done flag once the last byte has been taken. Software clears that flag with an acknowledge strobe before it may launch again. While a request is in flight the buffer and its settings are frozen.

Top module: `aux_req_frame_buf`

## Requirements
- R1: After reset, txValid, busy and done are all 0.
- R2: A header write stores byte 0 = {command[3:0], address[19:16]}, byte 1 = address[15:8] and byte 2 = address[7:0].
- R3: A header write with non-zero length L also stores byte 3 = L-1, and leaves the write pointer at 4. With L = 0, byte 3 is not written and the pointer is left at 3. A header write also turns auto-increment back on.
- R4: A header write sets the byte count to 3 when L = 0 and to 4 when L is non-zero, plus L when the request is a write.
- R5: An index write sets the write pointer and the auto-increment mode. With auto-increment on, each data write stores at the pointer and then advances it by one.
- R6: With auto-increment off (the index write's disable bit = 1), successive data writes land on the same index.
- R7: The buffer holds DEPTH (20) bytes. A data write while the pointer is at DEPTH or above is dropped and does not wrap onto low indices.
- R8: A count write loads the byte count. A value above DEPTH saturates to DEPTH. A delay write loads the start delay.
- R9: After a go strobe accepted at clock edge E0 with delay D, txValid first rises after edge E0 when D = 0, and after edge E0+D otherwise.
- R10: The stream presents bytes 0 through count-1 in order, one per cycle with txValid and txReady both high. While txReady is low, txValid and txData hold.
- R11: done rises and txValid and busy fall in the cycle after the last byte is accepted. A go with count 0 sets done in the next cycle without any stream byte.
- R12: A go strobe is ignored while busy or while done is 1. An acknowledge strobe clears done.
- R13: Header, index, data, count and delay writes are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrWrEn | input | 1 | Header write strobe |
| hdrCmd | input | 4 | Request command nibble |
| hdrAddr | input | 20 | Request address |
| hdrLen | input | IDX_W (5) | Transfer length, 0 for none |
| hdrIsWrite | input | 1 | Request carries payload bytes |
| idxWrEn | input | 1 | Index write strobe |
| idxVal | input | IDX_W (5) | New write pointer |
| idxAutoIncOff | input | 1 | 1 keeps the pointer fixed on data writes |
| dataWrEn | input | 1 | Data byte write strobe |
| dataByte | input | 8 | Byte stored at the pointer |
| dlyWrEn | input | 1 | Start-delay write strobe |
| dlyVal | input | DLY_W (8) | Start delay in cycles |
| cntWrEn | input | 1 | Byte-count write strobe |
| cntVal | input | IDX_W (5) | Byte count, saturated to DEPTH |
| goStb | input | 1 | Launch strobe |
| ackStb | input | 1 | Clears done |
| txValid | output | 1 | Stream byte valid |
| txReady | input | 1 | Stream consumer ready |
| txData | output | 8 | Stream byte |
| busy | output | 1 | Request in flight (delay or streaming) |
| done | output | 1 | Request completed, awaiting acknowledge |

## Verification
The assertions check on every cycle the parts of the design that are local rules. These are: the stream holding steady under back-pressure, done following the final handshake, done excluding txValid, rejected launches while done is set, acknowledge clearing done, the frozen settings while busy, the fixed pointer when auto-increment is off, the count never exceeding the depth, and the read index staying in range. What ends up in the byte stream only shows in the bench's scenarios. That covers the header packing for each length and direction, the computed byte count, the length of the start delay, the pointer landing points, the drop beyond index 19, and a launch during the delay leaving the request unchanged.

// File: rtl/aux_frame_pkg.sv
package aux_frame_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic launch;   // accepted go: rewind read index
    logic advance;  // byte handshake: step read index
  } ctlStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } engState_t;

endpackage

// File: rtl/aux_frame_dp.sv
module aux_frame_dp
  import aux_frame_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int DLY_W = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busy,
  input  logic             hdrWrEn,
  input  logic [3:0]       hdrCmd,
  input  logic [19:0]      hdrAddr,
  input  logic [IDX_W-1:0] hdrLen,
  input  logic             hdrIsWrite,
  input  logic             idxWrEn,
  input  logic [IDX_W-1:0] idxVal,
  input  logic             idxAutoIncOff,
  input  logic             dataWrEn,
  input  logic [7:0]       dataByte,
  input  logic             dlyWrEn,
  input  logic [DLY_W-1:0] dlyVal,
  input  logic             cntWrEn,
  input  logic [IDX_W-1:0] cntVal,
  input  ctlStrb_t         strb,
  output logic [7:0]       txData,
  output logic [IDX_W-1:0] cfgCount,
  output logic [DLY_W-1:0] cfgDelay
);

  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

  logic             swEn;
  logic [IDX_W-1:0] wrPtr;
  logic             autoIncOff;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] hdrBase;
  logic [IDX_W:0]   hdrSum;
  logic             dataHit;
  logic [DEPTH*8-1:0] bufFlat;

  function automatic logic [IDX_W-1:0] clampCnt(input logic [IDX_W:0] v);
    return (v > (IDX_W+1)'(DEPTH)) ? DEPTH_I : v[IDX_W-1:0];
  endfunction

  assign swEn    = !busy;
  assign dataHit = swEn && dataWrEn && !hdrWrEn && !idxWrEn;

  always_comb begin
    hdrBase = (hdrLen != '0) ? IDX_W'(4) : IDX_W'(3);
    hdrSum  = {1'b0, hdrBase} + (hdrIsWrite ? {1'b0, hdrLen} : '0);
  end

  // Buffer entries: header packing has priority over indexed data writes
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic [7:0] entQ;
    logic       hdrHit;
    logic [7:0] hdrVal;
    always_comb begin
      hdrHit = hdrWrEn;
      hdrVal = '0;
      case (gi)
        0: hdrVal = {hdrCmd, hdrAddr[19:16]};
        1: hdrVal = hdrAddr[15:8];
        2: hdrVal = hdrAddr[7:0];
        3: begin
          hdrVal = 8'(hdrLen) - 8'd1;
          hdrHit = hdrWrEn && (hdrLen != '0);
        end
        default: hdrHit = 1'b0;
      endcase
    end
    always_ff @(posedge clk) begin
      if (swEn && hdrHit)
        entQ <= hdrVal;
      else if (dataHit && wrPtr == IDX_W'(gi))
        entQ <= dataByte;
    end
    assign bufFlat[gi*8 +: 8] = entQ;
  end

  // Write pointer and auto-increment mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      autoIncOff <= 1'b0;
    end else if (swEn) begin
      if (hdrWrEn) begin
        wrPtr      <= hdrBase;
        autoIncOff <= 1'b0;
      end else if (idxWrEn) begin
        wrPtr      <= idxVal;
        autoIncOff <= idxAutoIncOff;
      end else if (dataWrEn && !autoIncOff && wrPtr < DEPTH_I) begin
        wrPtr <= wrPtr + IDX_W'(1);
      end
    end
  end

  // Count and delay settings
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCount <= '0;
      cfgDelay <= '0;
    end else if (swEn) begin
      if (hdrWrEn)      cfgCount <= clampCnt(hdrSum);
      else if (cntWrEn) cfgCount <= clampCnt({1'b0, cntVal});
      if (dlyWrEn)      cfgDelay <= dlyVal;
    end
  end

  // Read index for the outgoing stream
  always_ff @(posedge clk) begin
    if (!rstN)             rdIdx <= '0;
    else if (strb.launch)  rdIdx <= '0;
    else if (strb.advance) rdIdx <= rdIdx + IDX_W'(1);
  end

  always_comb begin
    txData = '0;
    for (int k = 0; k < DEPTH; k++)
      if (rdIdx == IDX_W'(k)) txData = bufFlat[k*8 +: 8];
  end

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> rdIdx < DEPTH_I); // R10
  AST_AUTOINC_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    dataHit && autoIncOff |=> $stable(wrPtr)); // R6
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfgCount) && $stable(cfgDelay)); // R13
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    cfgCount <= DEPTH_I); // R8

endmodule

// File: rtl/aux_frame_ctl.sv
module aux_frame_ctl
  import aux_frame_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goStb,
  input  logic             ackStb,
  input  logic             txReady,
  input  logic [IDX_W-1:0] cfgCount,
  input  logic [DLY_W-1:0] cfgDelay,
  output ctlStrb_t         strb,
  output logic             txValid,
  output logic             busy,
  output logic             done
);

  engState_t        state;
  logic [IDX_W-1:0] left;
  logic [DLY_W-1:0] dcnt;
  logic             goOk;
  logic             lastAcc;

  assign goOk         = (state == ST_IDLE) && goStb && !done;
  assign txValid      = (state == ST_SEND);
  assign busy         = (state != ST_IDLE);
  assign lastAcc      = txValid && txReady && (left == IDX_W'(1));
  assign strb.launch  = goOk;
  assign strb.advance = txValid && txReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      left  <= '0;
      dcnt  <= '0;
      done  <= 1'b0;
    end else begin
      if (ackStb) done <= 1'b0;
      case (state)
        ST_IDLE: if (goOk) begin
          if (cfgCount == '0) begin
            done <= 1'b1;
          end else begin
            left  <= cfgCount;
            dcnt  <= cfgDelay;
            state <= (cfgDelay == '0) ? ST_SEND : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dcnt <= DLY_W'(1)) state <= ST_SEND;
          else                   dcnt  <= dcnt - DLY_W'(1);
        end
        ST_SEND: if (txReady) begin
          left <= left - IDX_W'(1);
          if (left == IDX_W'(1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    lastAcc |=> done && !busy && !txValid); // R11
  AST_NO_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !txValid); // R11
  AST_GO_IGNORED_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done && !busy && goStb && !ackStb |=> done && !busy); // R12
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ackStb && !busy && !goStb |=> !done); // R12

endmodule

// File: rtl/aux_req_frame_buf.sv
module aux_req_frame_buf
  import aux_frame_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int DLY_W = 8,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdrWrEn,
  input  logic [3:0]       hdrCmd,
  input  logic [19:0]      hdrAddr,
  input  logic [IDX_W-1:0] hdrLen,
  input  logic             hdrIsWrite,
  input  logic             idxWrEn,
  input  logic [IDX_W-1:0] idxVal,
  input  logic             idxAutoIncOff,
  input  logic             dataWrEn,
  input  logic [7:0]       dataByte,
  input  logic             dlyWrEn,
  input  logic [DLY_W-1:0] dlyVal,
  input  logic             cntWrEn,
  input  logic [IDX_W-1:0] cntVal,
  input  logic             goStb,
  input  logic             ackStb,
  output logic             txValid,
  input  logic             txReady,
  output logic [7:0]       txData,
  output logic             busy,
  output logic             done
);

  ctlStrb_t         strb;
  logic [IDX_W-1:0] cfgCount;
  logic [DLY_W-1:0] cfgDelay;

  aux_frame_dp #(.DEPTH(DEPTH), .DLY_W(DLY_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .busy(busy),
    .hdrWrEn(hdrWrEn), .hdrCmd(hdrCmd), .hdrAddr(hdrAddr),
    .hdrLen(hdrLen), .hdrIsWrite(hdrIsWrite),
    .idxWrEn(idxWrEn), .idxVal(idxVal), .idxAutoIncOff(idxAutoIncOff),
    .dataWrEn(dataWrEn), .dataByte(dataByte),
    .dlyWrEn(dlyWrEn), .dlyVal(dlyVal),
    .cntWrEn(cntWrEn), .cntVal(cntVal),
    .strb(strb), .txData(txData),
    .cfgCount(cfgCount), .cfgDelay(cfgDelay)
  );

  aux_frame_ctl #(.DLY_W(DLY_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .goStb(goStb), .ackStb(ackStb),
    .txReady(txReady), .cfgCount(cfgCount), .cfgDelay(cfgDelay),
    .strb(strb), .txValid(txValid), .busy(busy), .done(done)
  );

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData)); // R10

endmodule

// File: tb/aux_req_frame_buf_tb.sv
`timescale 1ns/1ps
module aux_req_frame_buf_tb;

  localparam int DEPTH = 20;
  localparam int DLY_W = 8;
  localparam int IDX_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [3:0]  cmd;
    logic [19:0] addr;
    logic [4:0]  len;
    logic        isWr;
    logic [7:0]  dly;
    logic [7:0]  seed;
    logic [1:0]  rdyMode;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{cmd: 4'h9, addr: 20'h12345, len: 5'd0,  isWr: 1'b0, dly: 8'd0, seed: 8'h00, rdyMode: 2'd0},
    '{cmd: 4'h8, addr: 20'hABCDE, len: 5'd4,  isWr: 1'b1, dly: 8'd3, seed: 8'h10, rdyMode: 2'd1},
    '{cmd: 4'h9, addr: 20'h0F00F, len: 5'd16, isWr: 1'b0, dly: 8'd1, seed: 8'h00, rdyMode: 2'd2},
    '{cmd: 4'h0, addr: 20'hFFFFF, len: 5'd16, isWr: 1'b1, dly: 8'd2, seed: 8'hE0, rdyMode: 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrWrEn = 0, hdrIsWrite = 0, idxWrEn = 0, idxAutoIncOff = 0;
  logic dataWrEn = 0, dlyWrEn = 0, cntWrEn = 0, goStb = 0, ackStb = 0;
  logic txReady = 0;
  logic [3:0] hdrCmd = '0;
  logic [19:0] hdrAddr = '0;
  logic [IDX_W-1:0] hdrLen = '0, idxVal = '0, cntVal = '0;
  logic [7:0] dataByte = '0;
  logic [DLY_W-1:0] dlyVal = '0;
  logic txValid, busy, done;
  logic [7:0] txData;

  int nChk = 0;
  int nFail = 0;
  logic [7:0] got [32];
  int nGot;
  int dlyGot;
  logic [7:0] expB [32];

  always #2 clk = ~clk;

  aux_req_frame_buf #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .hdrWrEn(hdrWrEn), .hdrCmd(hdrCmd), .hdrAddr(hdrAddr),
    .hdrLen(hdrLen), .hdrIsWrite(hdrIsWrite),
    .idxWrEn(idxWrEn), .idxVal(idxVal), .idxAutoIncOff(idxAutoIncOff),
    .dataWrEn(dataWrEn), .dataByte(dataByte),
    .dlyWrEn(dlyWrEn), .dlyVal(dlyVal),
    .cntWrEn(cntWrEn), .cntVal(cntVal),
    .goStb(goStb), .ackStb(ackStb),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wrHdr(input logic [3:0] c, input logic [19:0] a, input int l, input logic w);
    hdrWrEn = 1; hdrCmd = c; hdrAddr = a; hdrLen = IDX_W'(l); hdrIsWrite = w;
    tick(); hdrWrEn = 0;
  endtask

  task automatic wrIdx(input int i, input logic off);
    idxWrEn = 1; idxVal = IDX_W'(i); idxAutoIncOff = off;
    tick(); idxWrEn = 0;
  endtask

  task automatic wrData(input logic [7:0] b);
    dataWrEn = 1; dataByte = b;
    tick(); dataWrEn = 0;
  endtask

  task automatic wrDly(input int d);
    dlyWrEn = 1; dlyVal = DLY_W'(d);
    tick(); dlyWrEn = 0;
  endtask

  task automatic wrCnt(input int n);
    cntWrEn = 1; cntVal = IDX_W'(n);
    tick(); cntWrEn = 0;
  endtask

  task automatic pulseGo();
    goStb = 1; tick(); goStb = 0;
  endtask

  task automatic pulseAck();
    ackStb = 1; tick(); ackStb = 0;
  endtask

  function automatic logic rdyAt(input logic [1:0] mode, input int cyc);
    case (mode)
      2'd1:    return cyc[0];
      2'd2:    return (cyc % 3) == 2;
      default: return 1'b1;
    endcase
  endfunction

  // Called at the first falling edge after the launch edge
  task automatic capture(input logic [1:0] mode);
    int guard;
    int cyc;
    nGot = 0; dlyGot = 0; guard = 0; cyc = 0;
    txReady = 0;
    while (!txValid && guard < 500) begin
      dlyGot++; guard++; tick();
    end
    while (txValid && guard < 2000) begin
      logic r;
      r = rdyAt(mode, cyc);
      txReady = r;
      if (r && nGot < 32) begin
        got[nGot] = txData;
        nGot++;
      end
      cyc++; guard++; tick();
    end
    txReady = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    // R1: reset state
    chk("R1 txValid", 32'(txValid), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    rstN = 1;
    tick();

    // Table-driven requests: R2 R3 R4 R9 R10 R11
    for (int v = 0; v < 4; v++) begin
      vec_t t;
      int n;
      t = VECS[v];
      n = (t.len != 0 ? 4 : 3) + (t.isWr ? int'(t.len) : 0);
      expB[0] = {t.cmd, t.addr[19:16]};
      expB[1] = t.addr[15:8];
      expB[2] = t.addr[7:0];
      if (t.len != 0) expB[3] = 8'(t.len) - 8'd1;
      for (int i = 0; i < 16; i++) expB[4 + i] = t.seed + 8'(i);
      wrHdr(t.cmd, t.addr, int'(t.len), t.isWr);
      if (t.isWr) for (int i = 0; i < int'(t.len); i++) wrData(t.seed + 8'(i));
      wrDly(int'(t.dly));
      pulseGo();
      capture(t.rdyMode);
      chk("R4 byte count", 32'(nGot), 32'(n));
      chk("R9 start delay", 32'(dlyGot), 32'(t.dly));
      for (int i = 0; i < n && i < nGot; i++) begin
        if (i < 3)      chk("R2 header byte", 32'(got[i]), 32'(expB[i]));
        else if (i == 3) chk("R3 length byte", 32'(got[i]), 32'(expB[i]));
        else            chk("R10 payload byte", 32'(got[i]), 32'(expB[i]));
      end
      chk("R11 done after last", 32'(done), 1);
      chk("R11 busy low", 32'(busy), 0);
      if (v < 3) begin
        pulseAck();
        chk("R12 ack clears done", 32'(done), 0);
      end
    end

    // R12: go while done is set is ignored
    pulseGo();
    chk("R12 go with done busy", 32'(busy), 0);
    chk("R12 go with done valid", 32'(txValid), 0);
    tick();
    chk("R12 go with done still idle", 32'(busy), 0);
    pulseAck();
    chk("R12 ack clears done", 32'(done), 0);

    // R12 R13: go and writes during the delay phase are ignored
    wrHdr(4'h1, 20'h00000, 0, 1'b0);
    wrDly(6);
    pulseGo();
    pulseGo();
    wrIdx(0, 1'b0);
    wrData(8'hAA);
    wrCnt(10);
    wrDly(0);
    capture(2'd0);
    chk("R13 count frozen", 32'(nGot), 3);
    chk("R13 byte0 frozen", 32'(got[0]), 32'h10);
    tick();
    chk("R12 second go ignored", 32'(busy), 0);
    pulseAck();

    // R5 R6: index write and auto-increment control
    wrIdx(5, 1'b1);
    wrData(8'h55);
    wrData(8'h66);
    wrIdx(6, 1'b0);
    wrData(8'h77);
    wrData(8'h88);
    wrCnt(8);
    wrDly(0);
    pulseGo();
    capture(2'd0);
    chk("R5 count", 32'(nGot), 8);
    chk("R6 same index overwrite", 32'(got[5]), 32'h66);
    chk("R5 index byte", 32'(got[6]), 32'h77);
    chk("R5 auto-increment", 32'(got[7]), 32'h88);
    pulseAck();

    // R7 R8: drop beyond last index, count saturates
    wrIdx(19, 1'b0);
    wrData(8'hC3);
    wrData(8'h3C);
    wrData(8'h99);
    wrCnt(31);
    pulseGo();
    capture(2'd0);
    chk("R8 count saturates", 32'(nGot), 20);
    chk("R7 last index byte", 32'(got[19]), 32'hC3);
    chk("R7 no wrap to index 0", 32'(got[0]), 32'h10);
    chk("R7 no wrap to index 1", 32'(got[1]), 32'h00);
    pulseAck();

    // R11: zero count completes without stream bytes
    wrCnt(0);
    pulseGo();
    chk("R11 zero count done", 32'(done), 1);
    chk("R11 zero count no valid", 32'(txValid), 0);
    pulseAck();
    chk("R12 ack after zero count", 32'(done), 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule